// File: doc/BRIEF.md
# Flash Operation Status Bit Generator

This block forms the byte a host receives when it reads a NOR-style flash memory while an internal program or erase job is running or suspended. Three bits carry status: a polling bit (bit 7) that shows the inverse of the top data bit while a byte is being written, and two toggle bits (bit 6 and bit 2). A host reads twice in a row and compares these bits. From that it can tell three cases apart: a job still in progress, a sector erase that is running, and a sector erase that has been suspended.

The current operation mode comes from the command logic. The byte being programmed, its address and the index of the erased or suspended sector come with it. Each host read presents an address together with a read strobe. When a read falls outside the status-reporting conditions, the byte from the memory array passes through unchanged. The output byte is registered. Each toggle bit is a flip-flop that inverts once a qualified read ends, so every read returns the value held before that read's inversion.

Top module: `flash_status_gen`

## Requirements
- R1: After the synchronous reset, rd_data_o is 8'h00 and both toggle bits are 0, so the first status read after reset shows 0 in each bit that toggles.
- R2: In program mode (mode_i = 1), every read returns a status byte: bit 7 is the inverse of prog_data_i[7], bit 6 is the bit-6 toggle value, bit 2 is 1, and bits 5, 4, 3, 1 and 0 are 0. Each such read inverts the bit-6 toggle.
- R3: In erase mode (mode_i = 2), every read returns a status byte with bit 7 = 0, bit 6 = the bit-6 toggle value, bit 2 = the bit-2 toggle value, and all other bits 0. Every read inverts the bit-6 toggle. Only reads inside the erased sector invert the bit-2 toggle.
- R4: In erase-suspend-read mode (mode_i = 3), a read inside the suspended sector returns bit 7 = 1, bit 6 = 1, bit 2 = the bit-2 toggle value and all other bits 0. The read inverts the bit-2 toggle and leaves the bit-6 toggle unchanged.
- R5: In erase-suspend-read mode, a read outside the suspended sector returns array_data_i and changes neither toggle.
- R6: In erase-suspend-program mode (mode_i = 4), a read at prog_addr_i outside the suspended sector returns bit 7 = inverse of prog_data_i[7], bit 6 = the bit-6 toggle value, bit 2 = 1 and all other bits 0, and inverts the bit-6 toggle. A read inside the suspended sector behaves as in R4. Any other read returns array_data_i and changes neither toggle.
- R7: In idle mode (mode_i = 0, and codes 5 to 7 are treated as idle), every read returns array_data_i and neither toggle changes.
- R8: Both toggles clear to 0 when a new job starts. A job starts when the mode goes from idle to program or to erase, or from erase-suspend-read to erase-suspend-program. Resuming an erase (erase-suspend-read to erase) does not clear them.
- R9: rd_data_o is updated at each clock edge where rd_strobe_i is high and holds its value while rd_strobe_i is low. The toggles invert on the clock edge where rd_strobe_i is seen low after being high. A strobe held high over several cycles therefore counts as a single read and returns the same byte each cycle.
- R10: A read lies inside the sector when the read address bits above SECT_BITS equal sect_i. The bit-6 status read of R6 also requires all ADDR_W address bits to equal prog_addr_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 3 | Operation mode: 0 idle, 1 program, 2 erase, 3 erase-suspend-read, 4 erase-suspend-program |
| prog_data_i | input | 8 | Byte being programmed |
| prog_addr_i | input | ADDR_W | Byte address being programmed |
| sect_i | input | ADDR_W-SECT_BITS | Index of the sector being erased or suspended |
| rd_strobe_i | input | 1 | Read strobe, high for the duration of a read |
| rd_addr_i | input | ADDR_W | Read address |
| array_data_i | input | 8 | Byte from the memory array at rd_addr_i |
| rd_data_o | output | 8 | Registered read data or status byte |

## Verification
A toggle flip-flop that holds a wrong value, or that fails to advance, shows up at the second read in the affected mode. Two successive status reads then return the same bit 6 or bit 2, or return them in the wrong phase. A wrong sector or address decision shows up on the very first read: the byte returned is array data where status was expected, or status where array data was expected. A missing clear or a spurious clear at a job start shows up as a wrong phase on the first status read of the new job, one cycle after the strobe.

// File: rtl/flash_status_pkg.sv
package flash_status_pkg;

  typedef enum logic [2:0] {
    MODE_IDLE      = 3'd0,
    MODE_PROG      = 3'd1,
    MODE_ERASE     = 3'd2,
    MODE_SUSP_READ = 3'd3,
    MODE_SUSP_PROG = 3'd4
  } fsg_mode_e;

  localparam int unsigned NUM_TOGGLES = 2;
  localparam int unsigned TOG_B6 = 0;
  localparam int unsigned TOG_B2 = 1;

  function automatic logic [7:0] status_byte(input logic b7, input logic b6, input logic b2);
    status_byte = {b7, b6, 3'b000, b2, 2'b00};
  endfunction

endpackage

// File: rtl/fsg_sector_match.sv
module fsg_sector_match #(
  parameter int unsigned IDX_W = 3
) (
  input  logic [IDX_W-1:0] rd_idx_i,
  input  logic [IDX_W-1:0] sect_i,
  output logic             hit_o
);
  always_comb hit_o = (rd_idx_i == sect_i);
endmodule

// File: rtl/fsg_toggle_cell.sv
module fsg_toggle_cell (
  input  logic clk,
  input  logic rst,
  input  logic clr_i,
  input  logic fall_i,
  input  logic qual_i,
  output logic tog_o
);
  always_ff @(posedge clk) begin
    if (rst || clr_i) tog_o <= 1'b0;
    else if (fall_i && qual_i) tog_o <= ~tog_o;
  end

  // R8: a job start leaves the toggle at zero
  p_clear_zero_r8: assert property (@(posedge clk) disable iff (rst) clr_i |=> !tog_o);
  // R9: without a completed qualified read the toggle holds
  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (!clr_i && !(fall_i && qual_i)) |=> $stable(tog_o));
endmodule

// File: rtl/fsg_read_classify.sv
module fsg_read_classify
  import flash_status_pkg::*;
#(
  parameter int unsigned ADDR_W = 19
) (
  input  logic [2:0]        mode_i,
  input  logic              in_sect_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  logic [ADDR_W-1:0] prog_addr_i,
  input  logic [7:0]        prog_data_i,
  input  logic [7:0]        array_data_i,
  input  logic [NUM_TOGGLES-1:0] tog_i,
  output logic [7:0]        byte_o,
  output logic [NUM_TOGGLES-1:0] qual_o
);
  fsg_mode_e mode;
  logic      at_prog;

  always_comb begin
    mode    = fsg_mode_e'(mode_i);
    at_prog = (rd_addr_i == prog_addr_i);
    byte_o  = array_data_i;
    qual_o  = '0;
    unique case (mode)
      MODE_PROG: begin
        byte_o         = status_byte(~prog_data_i[7], tog_i[TOG_B6], 1'b1);
        qual_o[TOG_B6] = 1'b1;
      end
      MODE_ERASE: begin
        byte_o         = status_byte(1'b0, tog_i[TOG_B6], tog_i[TOG_B2]);
        qual_o[TOG_B6] = 1'b1;
        qual_o[TOG_B2] = in_sect_i;
      end
      MODE_SUSP_READ, MODE_SUSP_PROG: begin
        if (in_sect_i) begin
          byte_o         = status_byte(1'b1, 1'b1, tog_i[TOG_B2]);
          qual_o[TOG_B2] = 1'b1;
        end else if (mode == MODE_SUSP_PROG && at_prog) begin
          byte_o         = status_byte(~prog_data_i[7], tog_i[TOG_B6], 1'b1);
          qual_o[TOG_B6] = 1'b1;
        end
      end
      default: begin
        byte_o = array_data_i;
      end
    endcase
  end
endmodule

// File: rtl/flash_status_gen.sv
module flash_status_gen
  import flash_status_pkg::*;
#(
  parameter int unsigned ADDR_W    = 19,
  parameter int unsigned SECT_BITS = 16
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [2:0]            mode_i,
  input  logic [7:0]            prog_data_i,
  input  logic [ADDR_W-1:0]     prog_addr_i,
  input  logic [ADDR_W-SECT_BITS-1:0] sect_i,
  input  logic                  rd_strobe_i,
  input  logic [ADDR_W-1:0]     rd_addr_i,
  input  logic [7:0]            array_data_i,
  output logic [7:0]            rd_data_o
);
  localparam int unsigned IDX_W = ADDR_W - SECT_BITS;

  logic [2:0]             mode_q;
  logic                   strobe_q;
  logic                   fall;
  logic                   clr;
  logic                   in_sect;
  logic [7:0]             next_byte;
  logic [NUM_TOGGLES-1:0] qual_now, qual_q, tog;

  fsg_sector_match #(.IDX_W(IDX_W)) u_match (
    .rd_idx_i (rd_addr_i[ADDR_W-1:SECT_BITS]),
    .sect_i   (sect_i),
    .hit_o    (in_sect)
  );

  fsg_read_classify #(.ADDR_W(ADDR_W)) u_class (
    .mode_i       (mode_i),
    .in_sect_i    (in_sect),
    .rd_addr_i    (rd_addr_i),
    .prog_addr_i  (prog_addr_i),
    .prog_data_i  (prog_data_i),
    .array_data_i (array_data_i),
    .tog_i        (tog),
    .byte_o       (next_byte),
    .qual_o       (qual_now)
  );

  always_comb begin
    fall = strobe_q && !rd_strobe_i;
    clr  = (mode_q == MODE_IDLE && (mode_i == MODE_PROG || mode_i == MODE_ERASE)) ||
           (mode_q == MODE_SUSP_READ && mode_i == MODE_SUSP_PROG);
  end

  genvar g;
  generate
    for (g = 0; g < NUM_TOGGLES; g++) begin : g_tog
      fsg_toggle_cell u_cell (
        .clk    (clk),
        .rst    (rst),
        .clr_i  (clr),
        .fall_i (fall),
        .qual_i (qual_q[g]),
        .tog_o  (tog[g])
      );
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q    <= MODE_IDLE;
      strobe_q  <= 1'b0;
      qual_q    <= '0;
      rd_data_o <= 8'h00;
    end else begin
      mode_q   <= mode_i;
      strobe_q <= rd_strobe_i;
      if (rd_strobe_i) begin
        qual_q    <= qual_now;
        rd_data_o <= next_byte;
      end
    end
  end

  // R9: output holds between reads
  p_out_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !rd_strobe_i |=> $stable(rd_data_o));
  // R3: erase status always shows a low polling bit
  p_erase_poll_r3: assert property (@(posedge clk) disable iff (rst)
    (rd_strobe_i && mode_i == MODE_ERASE) |=> !rd_data_o[7]);
  // R2: program status shows inverted data bit and a set bit 2
  p_prog_poll_r2: assert property (@(posedge clk) disable iff (rst)
    (rd_strobe_i && mode_i == MODE_PROG) |=> (rd_data_o[2] && rd_data_o[7] == !$past(prog_data_i[7])));
  // R4: suspended sector reads show both upper status bits set
  p_susp_sect_r4: assert property (@(posedge clk) disable iff (rst)
    (rd_strobe_i && mode_i == MODE_SUSP_READ && in_sect) |=> rd_data_o[7:6] == 2'b11);
  // R7: idle reads pass array data through
  p_idle_pass_r7: assert property (@(posedge clk) disable iff (rst)
    (rd_strobe_i && mode_i == MODE_IDLE) |=> rd_data_o == $past(array_data_i));
endmodule

// File: tb/flash_status_gen_tb_top.sv
module flash_status_gen_tb_top;
  localparam int unsigned ADDR_W = 19;
  localparam int unsigned SECT_BITS = 16;
  localparam int unsigned IDX_W = ADDR_W - SECT_BITS;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [2:0] mode_i = 3'd0;
  logic [7:0] prog_data_i = 8'h00;
  logic [ADDR_W-1:0] prog_addr_i = '0;
  logic [IDX_W-1:0] sect_i = '0;
  logic rd_strobe_i = 1'b0;
  logic [ADDR_W-1:0] rd_addr_i = '0;
  logic [7:0] array_data_i = 8'h00;
  logic [7:0] rd_data_o;

  int checks = 0;
  int errors = 0;
  bit m6 = 1'b0, m2 = 1'b0;
  logic [2:0] cur_mode = 3'd0;

  always #2 clk = ~clk;

  flash_status_gen #(.ADDR_W(ADDR_W), .SECT_BITS(SECT_BITS)) dut_i (
    .clk(clk), .rst(rst), .mode_i(mode_i), .prog_data_i(prog_data_i),
    .prog_addr_i(prog_addr_i), .sect_i(sect_i), .rd_strobe_i(rd_strobe_i),
    .rd_addr_i(rd_addr_i), .array_data_i(array_data_i), .rd_data_o(rd_data_o));

  function automatic logic [7:0] sbyte(bit b7, bit b6, bit b2);
    return {b7, b6, 3'b000, b2, 2'b00};
  endfunction

  // expected byte and toggle qualifiers from the requirements
  function automatic logic [9:0] model(logic [2:0] md, logic [ADDR_W-1:0] a, bit t6, bit t2);
    bit insec;
    bit atp;
    insec = (a[ADDR_W-1:SECT_BITS] == sect_i);
    atp = (a == prog_addr_i);
    case (md)
      3'd1: return {2'b01, sbyte(~prog_data_i[7], t6, 1'b1)};
      3'd2: return {insec, 1'b1, sbyte(1'b0, t6, t2)};
      3'd3, 3'd4: begin
        if (insec) return {2'b10, sbyte(1'b1, 1'b1, t2)};
        if (md == 3'd4 && atp) return {2'b01, sbyte(~prog_data_i[7], t6, 1'b1)};
        return {2'b00, array_data_i};
      end
      default: return {2'b00, array_data_i};
    endcase
  endfunction

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic set_mode(logic [2:0] md);
    @(negedge clk);
    if ((cur_mode == 3'd0 && (md == 3'd1 || md == 3'd2)) || (cur_mode == 3'd3 && md == 3'd4)) begin
      m6 = 1'b0; m2 = 1'b0;
    end
    mode_i = md;
    cur_mode = md;
    @(negedge clk);
  endtask

  task automatic do_read(string req, logic [ADDR_W-1:0] a, logic [7:0] arr, int hold);
    logic [9:0] e;
    @(negedge clk);
    rd_addr_i = a; array_data_i = arr; rd_strobe_i = 1'b1;
    e = model(cur_mode, a, m6, m2);
    for (int i = 0; i < hold; i++) begin
      @(posedge clk); #1;
      check(req, rd_data_o, e[7:0]);
    end
    @(negedge clk);
    rd_strobe_i = 1'b0;
    array_data_i = ~arr;
    @(posedge clk); #1;
    check({req, " hold"}, rd_data_o, e[7:0]);
    if (e[8]) m6 = ~m6;
    if (e[9]) m2 = ~m2;
  endtask

  function automatic logic [ADDR_W-1:0] in_addr(logic [15:0] lo);
    return {sect_i, lo};
  endfunction

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED1234));
    sect_i = 3'd5;
    prog_addr_i = {3'd2, 16'h1234};
    prog_data_i = 8'h5A;
    repeat (3) @(posedge clk);
    #1 check("R1 reset", rd_data_o, 8'h00);
    @(negedge clk) rst = 1'b0;

    do_read("R7 idle", in_addr(16'h0001), 8'hC3, 1);
    set_mode(3'd1);
    do_read("R1 R2 program first", 19'h00010, 8'h11, 1);
    do_read("R2 program second", 19'h00020, 8'h11, 1);
    prog_data_i = 8'hA5;
    do_read("R2 program inv", 19'h00030, 8'h11, 1);
    do_read("R9 long strobe", 19'h00030, 8'h11, 3);
    do_read("R2 program after long", 19'h00030, 8'h11, 1);
    set_mode(3'd0);
    set_mode(3'd2);
    do_read("R8 R3 erase in sector", in_addr(16'h0100), 8'h00, 1);
    do_read("R3 erase outside", 19'h00100, 8'h00, 1);
    do_read("R3 R10 erase in sector", in_addr(16'hFFFF), 8'h00, 1);
    do_read("R10 sector edge below", {3'd4, 16'hFFFF}, 8'h00, 1);
    set_mode(3'd3);
    do_read("R4 susp sector", in_addr(16'h0002), 8'h77, 1);
    do_read("R4 susp sector again", in_addr(16'h0003), 8'h77, 1);
    do_read("R5 susp outside", 19'h12345, 8'h9C, 1);
    set_mode(3'd4);
    do_read("R8 R6 susp prog addr", prog_addr_i, 8'h01, 1);
    do_read("R6 susp prog addr again", prog_addr_i, 8'h01, 1);
    do_read("R6 susp prog other", prog_addr_i + 1'b1, 8'hE7, 1);
    do_read("R6 susp prog sector", in_addr(16'h0010), 8'hE7, 1);
    set_mode(3'd3);
    set_mode(3'd2);
    do_read("R8 resume no clear", in_addr(16'h0010), 8'h00, 1);

    for (int n = 0; n < 300; n++) begin
      if ($urandom_range(0, 7) == 0) begin
        set_mode(3'($urandom_range(0, 4)));
        prog_data_i = 8'($urandom);
      end
      if ($urandom_range(0, 3) == 0)
        do_read("R10 random prog addr", prog_addr_i, 8'($urandom), 1);
      else if ($urandom_range(0, 1) == 0)
        do_read("R3 random in sector", in_addr(16'($urandom)), 8'($urandom), $urandom_range(1, 2));
      else
        do_read("R5 random any", 19'($urandom), 8'($urandom), 1);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule